// File: doc/BRIEF.md
# DRAM refresh and restore controller

This block fronts a row-organised dynamic memory and keeps the data in it alive. Host reads and writes arrive on a valid/ready handshake and address one word inside one row. Opening a row senses the whole row into a latch and wipes the cells. So every access, read or write, is a fixed sequence: sense, restore, precharge. The restore writes the row back while it is still open. For a write, the addressed word is merged into the sensed row before the restore. For a read, the addressed word is returned on the response port.

A free-running refresh timer raises a request at a fixed spacing. A row pointer walks through every row in ascending order and wraps. Each refresh is the same sense-then-restore pair aimed at the pointer's row. The spacing is chosen so that each row is rewritten before its retention window closes. A pending refresh wins over a new host request but never cuts into an operation already under way.

The storage cells are inverting: sensing returns the complement of the stored level. The controller corrects for this on both paths. A behavioural cell array inside the block keeps a saturating age counter for every row. It raises a sticky decay flag if a row outlives the retention window, or if a row is sensed twice without a restore in between.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset, req_ready is 1, and resp_valid, rf_start and decay_err are 0; every location reads as 0.
- R2: A read that is accepted (req_write = 0) on a clock edge drives resp_valid high for exactly one cycle, starting on the second edge after the accepting edge. resp_rdata then carries the word last written to that row and column.
- R3: Every row sense is followed on the very next cycle by a restore of the same row. Repeated reads of one location therefore return the same word.
- R4: A write (req_write = 1) replaces only the addressed column word. The other column words of that row keep their values.
- R5: With no host traffic, a refresh starts every GAP = (RETENTION - 8) / ROWS cycles, which is 31 for the defaults. rf_start pulses for one cycle per refresh. rf_row gives the refreshed row: 0 first after reset, then 1, 2, ..., ROWS-1, 0, and so on.
- R6: A pending refresh blocks acceptance of new host requests and starts as soon as the current operation ends. Under saturating host traffic, the spacing between successive refresh starts stays within GAP-3 to GAP+3 cycles.
- R7: The cells store inverted levels. A written word still reads back unchanged after any number of refresh sweeps.
- R8: decay_err stays 0 under any host traffic: no row age exceeds RETENTION cycles, and no row is sensed twice without a restore.
- R9: A write produces no pulse on resp_valid.
- R10: req_ready is 0 for the three cycles after an accepting edge. A new request is accepted no earlier than the fourth edge after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and no refresh pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | $clog2(ROWS) | Row address |
| req_col | input | $clog2(COLS) | Column word within the row |
| req_wdata | input | DW | Write data |
| resp_valid | output | 1 | One-cycle read response strobe |
| resp_rdata | output | DW | Read data |
| rf_start | output | 1 | Pulses when a refresh senses its row |
| rf_row | output | $clog2(ROWS) | Row being refreshed, valid with rf_start |
| decay_err | output | 1 | Sticky flag: retention exceeded or double sense |

## Verification
Directed patterns come first. A read of never-written memory shows the reset contents. A single-word write followed by reads of all four columns separates a correct merge from a whole-row overwrite. Back-to-back reads of one word would expose a missing restore, because the second sense would find wiped cells.

A long idle stretch then covers several full refresh sweeps, and reading back afterwards shows whether the inverted polarity survives. The same stretch checks the exact refresh spacing and row order.

Last comes a seeded random phase of back-to-back mixed reads and writes against a shadow copy. It keeps the host port saturated, so it shows that refresh still gets in within its bound and that no row decays.

// File: rtl/dref_pkg.sv
package dref_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SENSE,
        ST_RESTORE,
        ST_PRECH
    } ctrl_state_e;

    typedef enum logic [1:0] {
        MC_NOP,
        MC_SENSE,
        MC_RESTORE
    } mcmd_e;

endpackage

// File: rtl/dref_timer.sv
module dref_timer #(
    parameter int GAP  = 31,
    parameter int ROWS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     take,
    output logic                     tick,
    output logic [$clog2(ROWS)-1:0]  row
);
    localparam int RW   = $clog2(ROWS);
    localparam int CNTW = (GAP > 1) ? $clog2(GAP) : 1;
    localparam logic [CNTW-1:0] LAST_CNT = CNTW'(GAP - 1);
    localparam logic [RW-1:0]   LAST_ROW = RW'(ROWS - 1);

    typedef struct packed {
        logic [CNTW-1:0] cnt;
        logic [RW-1:0]   row;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (q.cnt == LAST_CNT) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
        if (take) begin
            d.row = (q.row == LAST_ROW) ? '0 : q.row + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tick = (q.cnt == LAST_CNT);
    assign row  = q.row;

    // R5: each refresh that is taken moves the pointer on
    a_r5_row_moves: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (q.row != $past(q.row)));

    // R5: ticks are isolated pulses
    a_r5_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/dref_cell_array.sv
module dref_cell_array
    import dref_pkg::*;
#(
    parameter int ROWS      = 8,
    parameter int COLS      = 4,
    parameter int DW        = 8,
    parameter int RETENTION = 256,
    parameter int INVERT    = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  mcmd_e                       cmd,
    input  logic [$clog2(ROWS)-1:0]     row,
    input  logic [COLS*DW-1:0]          wr_row,
    output logic [COLS*DW-1:0]          rd_row,
    output logic                        err
);
    localparam int ROWW = COLS * DW;
    localparam int AGEW = $clog2(RETENTION + 2);
    localparam logic [AGEW-1:0] RET_LIM  = AGEW'(RETENTION);
    localparam logic [AGEW-1:0] AGE_SAT  = '1;
    localparam logic            INV_BIT  = (INVERT != 0);

    typedef struct packed {
        logic [ROWS-1:0][ROWW-1:0] cells;
        logic [ROWS-1:0][AGEW-1:0] age;
        logic [ROWS-1:0]           open;
        logic [ROWW-1:0]           sense;
        logic                      err;
    } arr_t;

    arr_t q, d;
    logic hit;

    always_comb begin
        d   = q;
        hit = 1'b0;
        for (int r = 0; r < ROWS; r++) begin
            if (q.age[r] > RET_LIM) begin
                hit = 1'b1;
            end
            if (q.age[r] != AGE_SAT) begin
                d.age[r] = q.age[r] + 1'b1;
            end
        end
        case (cmd)
            MC_SENSE: begin
                if (q.open[row]) begin
                    hit = 1'b1;
                end
                d.open[row]  = 1'b1;
                d.sense      = q.cells[row] ^ {ROWW{INV_BIT}};
                d.cells[row] = '0;
            end
            MC_RESTORE: begin
                d.cells[row] = wr_row;
                d.age[row]   = '0;
                d.open[row]  = 1'b0;
            end
            default: ;
        endcase
        d.err = q.err | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_row = q.sense;
    assign err    = q.err;

    // R8: decay flag never raised
    a_r8_no_decay: assert property (@(posedge clk) disable iff (!rst_n)
        !q.err);

    // R3: a sensed row is restored before it is sensed again
    a_r3_no_double_sense: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == MC_SENSE) |-> !q.open[row]);

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
    import dref_pkg::*;
#(
    parameter int ROWS      = 8,
    parameter int COLS      = 4,
    parameter int DW        = 8,
    parameter int RETENTION = 256,
    parameter int INVERT    = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_write,
    input  logic [$clog2(ROWS)-1:0]       req_row,
    input  logic [$clog2(COLS)-1:0]       req_col,
    input  logic [DW-1:0]                 req_wdata,
    output logic                          resp_valid,
    output logic [DW-1:0]                 resp_rdata,
    output logic                          rf_start,
    output logic [$clog2(ROWS)-1:0]       rf_row,
    output logic                          decay_err
);
    localparam int RW        = $clog2(ROWS);
    localparam int CW        = $clog2(COLS);
    localparam int ROWW      = COLS * DW;
    localparam int OP_CYCLES = 4;
    localparam int GAP       = (RETENTION - 2 * OP_CYCLES) / ROWS;

    typedef struct packed {
        ctrl_state_e      state;
        logic             is_ref;
        logic             is_wr;
        logic [RW-1:0]    row;
        logic [CW-1:0]    col;
        logic [DW-1:0]    wdata;
        logic             pend;
        logic             resp_v;
        logic [DW-1:0]    resp_d;
    } ctl_t;

    ctl_t q, d;

    logic            tick;
    logic            take;
    logic [RW-1:0]   t_row;
    mcmd_e           m_cmd;
    logic [ROWW-1:0] m_sense;
    logic [ROWW-1:0] logic_row;
    logic [ROWW-1:0] wr_row;
    logic [DW-1:0]   col_word [COLS];

    dref_timer #(
        .GAP  (GAP),
        .ROWS (ROWS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .tick  (tick),
        .row   (t_row)
    );

    dref_cell_array #(
        .ROWS      (ROWS),
        .COLS      (COLS),
        .DW        (DW),
        .RETENTION (RETENTION),
        .INVERT    (INVERT)
    ) u_cells (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (m_cmd),
        .row    (q.row),
        .wr_row (wr_row),
        .rd_row (m_sense),
        .err    (decay_err)
    );

    // The sensed level is inverted for inverting cells
    generate
        if (INVERT != 0) begin : g_inv
            assign logic_row = ~m_sense;
        end else begin : g_true
            assign logic_row = m_sense;
        end
    endgenerate

    // Column split and write merge
    generate
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign col_word[c] = logic_row[c*DW +: DW];
            assign wr_row[c*DW +: DW] =
                (q.is_wr && !q.is_ref && (q.col == CW'(c))) ? q.wdata
                                                            : logic_row[c*DW +: DW];
        end
    endgenerate

    assign take = (q.state == ST_IDLE) && q.pend;

    always_comb begin
        d        = q;
        d.resp_v = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (q.pend) begin
                    d.state  = ST_SENSE;
                    d.is_ref = 1'b1;
                    d.is_wr  = 1'b0;
                    d.row    = t_row;
                    d.pend   = 1'b0;
                end else if (req_valid) begin
                    d.state  = ST_SENSE;
                    d.is_ref = 1'b0;
                    d.is_wr  = req_write;
                    d.row    = req_row;
                    d.col    = req_col;
                    d.wdata  = req_wdata;
                end
            end
            ST_SENSE: begin
                d.state = ST_RESTORE;
            end
            ST_RESTORE: begin
                d.state = ST_PRECH;
                if (!q.is_ref && !q.is_wr) begin
                    d.resp_v = 1'b1;
                    d.resp_d = col_word[q.col];
                end
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
        if (tick) begin
            d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.state)
            ST_SENSE:   m_cmd = MC_SENSE;
            ST_RESTORE: m_cmd = MC_RESTORE;
            default:    m_cmd = MC_NOP;
        endcase
    end

    assign req_ready  = (q.state == ST_IDLE) && !q.pend;
    assign resp_valid = q.resp_v;
    assign resp_rdata = q.resp_d;
    assign rf_start   = (q.state == ST_SENSE) && q.is_ref;
    assign rf_row     = q.row;

    // R3: a sense is always followed by a restore of the same row
    a_r3_sense_then_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cmd == MC_SENSE) |=> ((m_cmd == MC_RESTORE) && $stable(q.row)));

    // R6: a pending refresh in idle starts on the next cycle
    a_r6_refresh_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_IDLE) && q.pend && req_valid) |=> rf_start);

    // R6: a refresh request never arrives while another is still waiting
    a_r6_single_pending: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> !q.pend);

    // R2: a response only follows a restore of a host read
    a_r2_resp_after_restore: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_valid) |-> ($past(m_cmd) == MC_RESTORE));

    // R10: acceptance is followed by a busy interval
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/dram_refresh_ctrl_bench.sv
module dram_refresh_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 8;
    localparam int COLS = 4;
    localparam int RET  = 256;
    localparam int GAP  = (RET - 8) / ROWS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_write = 1'b0;
    logic [2:0] req_row = '0;
    logic [1:0] req_col = '0;
    logic [7:0] req_wdata = '0;
    logic       resp_valid;
    logic [7:0] resp_rdata;
    logic       rf_start;
    logic [2:0] rf_row;
    logic       decay_err;

    int total = 0;
    int bad = 0;
    logic [7:0] shadow [ROWS][COLS];

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_refresh_ctrl u_dram_refresh_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .rf_start(rf_start), .rf_row(rf_row), .decay_err(decay_err)
    );

    task automatic check(input bit ok, input string rq,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] expect_word(input logic [2:0] r, input logic [1:0] c);
        return shadow[r][c];
    endfunction

    // Refresh monitor: R5 order and spacing, R6 bound, R8 flag
    int  cyc = 0;
    int  last_start = -1;
    int  exp_row = 0;
    bit  quiet = 1'b0;
    bit  quiet_span = 1'b0;
    bit  prev_quiet = 1'b0;
    bit  err_seen = 1'b0;
    int  strict_seen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!quiet) quiet_span = 1'b0;
            if (decay_err) err_seen = 1'b1;
            if (rf_start) begin
                check(rf_row == 3'(exp_row), "R5 row order", 32'(rf_row), 32'(exp_row));
                if (last_start >= 0) begin
                    if (quiet_span && prev_quiet) begin
                        strict_seen++;
                        check((cyc - last_start) == GAP, "R5 idle spacing",
                              32'(cyc - last_start), 32'(GAP));
                    end
                    check((cyc - last_start) >= GAP - 3 && (cyc - last_start) <= GAP + 3,
                          "R6 spacing bound", 32'(cyc - last_start), 32'(GAP));
                end
                last_start = cyc;
                prev_quiet = quiet_span;
                quiet_span = 1'b1;
                exp_row = (exp_row + 1) % ROWS;
            end
        end
    end

    task automatic do_op(input bit wr, input logic [2:0] r, input logic [1:0] c,
                         input logic [7:0] data);
        logic [7:0] ev;
        ev = expect_word(r, c);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_row = r; req_col = c; req_wdata = data;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R10 busy 1", 32'(req_ready), 32'd0);
        check(!resp_valid, "R2 early resp", 32'(resp_valid), 32'd0);
        @(negedge clk);
        check(!req_ready, "R10 busy 2", 32'(req_ready), 32'd0);
        check(!resp_valid, "R2 early resp", 32'(resp_valid), 32'd0);
        @(negedge clk);
        check(!req_ready, "R10 busy 3", 32'(req_ready), 32'd0);
        if (wr) begin
            check(!resp_valid, "R9 no write resp", 32'(resp_valid), 32'd0);
            shadow[r][c] = data;
        end else begin
            check(resp_valid, "R2 resp timing", 32'(resp_valid), 32'd1);
            check(resp_rdata == ev, "R2 R4 R7 read data", 32'(resp_rdata), 32'(ev));
        end
        @(negedge clk);
        check(!resp_valid, "R2 single pulse", 32'(resp_valid), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) shadow[r][c] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(req_ready, "R1 ready", 32'(req_ready), 32'd1);
        check(!resp_valid, "R1 resp", 32'(resp_valid), 32'd0);
        check(!rf_start, "R1 rf_start", 32'(rf_start), 32'd0);
        check(!decay_err, "R1 decay_err", 32'(decay_err), 32'd0);
        // R1 unwritten memory reads zero
        do_op(1'b0, 3'd5, 2'd3, 8'h00);
        // R4 single-word write, neighbours untouched
        do_op(1'b1, 3'd2, 2'd1, 8'hA5);
        for (int c = 0; c < COLS; c++) do_op(1'b0, 3'd2, 2'(c), 8'h00);
        do_op(1'b1, 3'd2, 2'd3, 8'h3C);
        do_op(1'b0, 3'd2, 2'd1, 8'h00);
        // R3 repeated reads of one location
        for (int k = 0; k < 3; k++) do_op(1'b0, 3'd2, 2'd3, 8'h00);
        do_op(1'b1, 3'd7, 2'd0, 8'hFF);
        do_op(1'b1, 3'd0, 2'd2, 8'h01);
        // R5 R7 idle window covering several sweeps
        quiet = 1'b1;
        repeat (8 * RET / 3) @(negedge clk);
        quiet = 1'b0;
        check(strict_seen > 0, "R5 idle spacing observed", 32'(strict_seen), 32'd1);
        do_op(1'b0, 3'd7, 2'd0, 8'h00);
        do_op(1'b0, 3'd0, 2'd2, 8'h00);
        do_op(1'b0, 3'd2, 2'd1, 8'h00);
        do_op(1'b0, 3'd2, 2'd3, 8'h00);
        // R6 R8 saturating random traffic
        for (int n = 0; n < 1500; n++) begin
            do_op(1'($urandom), 3'($urandom), 2'($urandom), 8'($urandom));
        end
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) do_op(1'b0, 3'(r), 2'(c), 8'h00);
        check(!err_seen && !decay_err, "R8 decay flag low", 32'(err_seen), 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule